// File: doc/BRIEF.md
# I2C Master Host Register Interface

This block is the register file that a host processor uses to drive an I2C master. The host reaches it over a small bus with a 3-bit address, 8-bit write and read data, and separate read and write strobes. The block holds a control word, a status word, a 16-bit clock divide value, a transmit byte and a receive byte. It turns host writes to the control word into single-cycle command pulses for a companion byte-level engine, which generates all bus signalling itself.

The engine reports back with three inputs. A completion strobe ends each operation. An acknowledge sample comes with that strobe. A byte-valid strobe carries the received data. The completion strobe raises a sticky interrupt request. The request stays set until the host writes the control word with the acknowledge bit set. A single interrupt output shows the request while the enable bit is held.

Top module: `i2cm_host_regs`

## Requirements
- R1: Register map by address: 0 control, 1 status, 2 divider bits 7..0, 3 divider bits 15..8, 4 transmit byte, 5 receive byte. While bus_rd is high, bus_rdata shows the addressed register in the same cycle.
- R2: Control bit layout: bit 7 nack, 6 start, 5 stop, 4 read, 3 write, 2 interrupt acknowledge, 1 interrupt enable. A control read returns only nack (bit 7) and enable (bit 1). Every other bit reads 0.
- R3: Status bit layout: bit 2 busy, bit 1 received acknowledge, bit 0 interrupt request. Bits 7..3 read 0. Host writes to address 1 have no effect.
- R4: After reset, every register reads 00h, every command output is 0 and irq_o is 0.
- R5: Any host write to address 0 sets busy in the next cycle. A done strobe alone clears busy. If a control write and a done strobe land in the same cycle, busy ends up 1.
- R6: A done strobe sets the interrupt request. The request clears only on a control write that has bit 2 set. A control write without bit 2 leaves it unchanged. If a done strobe and an acknowledging control write land in the same cycle, the request stays set.
- R7: irq_o is 1 exactly when the enable bit and the interrupt request are both 1.
- R8: The clk_div output carries the two divider bytes, and tx_data carries the transmit byte.
- R9: A control write with any of bits 6..3 set drives the matching cmd_start, cmd_stop, cmd_read or cmd_write high for exactly the one cycle after the write. cmd_nack follows bit 7 as a held level.
- R10: The receive byte changes only on eng_rxvalid, which loads eng_rxdata. Host writes to address 5 are ignored.
- R11: Reads from addresses 6 and 7 return 00h.
- R12: On a done strobe, the received-acknowledge status bit takes the value of eng_rxack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Read data (0 when bus_rd is low) |
| eng_done | input | 1 | Engine operation complete |
| eng_rxack | input | 1 | Acknowledge sampled by engine |
| eng_rxvalid | input | 1 | Received byte valid |
| eng_rxdata | input | 8 | Received byte |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_read | output | 1 | Read byte command pulse |
| cmd_write | output | 1 | Write byte command pulse |
| cmd_nack | output | 1 | Acknowledge level to send after a read byte |
| clk_div | output | 16 | Clock divide value |
| tx_data | output | 8 | Byte to transmit |
| irq_o | output | 1 | Interrupt request output |

## Verification
A host write to the control word and the engine's done strobe can arrive in the same clock cycle. They then act on busy and on the interrupt request in opposite directions. The bench drives both in one cycle, using a control write that carries the acknowledge bit. It then reads the status word and expects busy set, the request still set and the acknowledge bit taken from the engine. A separate acknowledging write then shows the request clearing on its own.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_DIVLO = 3'd2,
        A_DIVHI = 3'd3,
        A_TXD   = 3'd4,
        A_RXD   = 3'd5
    } reg_addr_e;

    // control word bit positions
    localparam int unsigned CB_NACK  = 7;
    localparam int unsigned CB_START = 6;
    localparam int unsigned CB_STOP  = 5;
    localparam int unsigned CB_RD    = 4;
    localparam int unsigned CB_WR    = 3;
    localparam int unsigned CB_IACK  = 2;
    localparam int unsigned CB_IEN   = 1;

    // status word bit positions
    localparam int unsigned SB_BUSY   = 2;
    localparam int unsigned SB_RXACK  = 1;
    localparam int unsigned SB_INTREQ = 0;

    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic iack;
    } cmd_t;

endpackage

// File: rtl/i2cm_ctrl_reg.sv
module i2cm_ctrl_reg
    import i2cm_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output cmd_t          cmd,
    output logic          nack_lvl,
    output logic          ien_lvl
);

    typedef struct packed {
        cmd_t cmd;
        logic nack;
        logic ien;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic unused_bit0;
    assign unused_bit0 = wdata[0];

    always_comb begin
        s_d     = s_q;
        s_d.cmd = '0;
        if (wr_en) begin
            s_d.cmd.start = wdata[CB_START];
            s_d.cmd.stop  = wdata[CB_STOP];
            s_d.cmd.rd    = wdata[CB_RD];
            s_d.cmd.wr    = wdata[CB_WR];
            s_d.cmd.iack  = wdata[CB_IACK];
            s_d.nack      = wdata[CB_NACK];
            s_d.ien       = wdata[CB_IEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd      = s_q.cmd;
    assign nack_lvl = s_q.nack;
    assign ien_lvl  = s_q.ien;

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ack_req,
    input  logic eng_done,
    input  logic eng_rxack,
    output logic busy,
    output logic intreq,
    output logic rxack
);

    typedef struct packed {
        logic busy;
        logic intreq;
        logic rxack;
    } stat_state_t;

    stat_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // busy: a control write outranks a completion in the same cycle
        if (eng_done) s_d.busy = 1'b0;
        if (ctrl_wr)  s_d.busy = 1'b1;
        // interrupt request: a completion outranks an acknowledge
        if (ctrl_wr && ack_req) s_d.intreq = 1'b0;
        if (eng_done)           s_d.intreq = 1'b1;
        if (eng_done)           s_d.rxack  = eng_rxack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign intreq = s_q.intreq;
    assign rxack  = s_q.rxack;

endmodule

// File: rtl/i2cm_data_regs.sv
module i2cm_data_regs
    import i2cm_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned DIV_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   rx_valid,
    input  logic [DW-1:0]          rx_byte,
    output logic [DW*DIV_BYTES-1:0] div_val,
    output logic [DW-1:0]          tx_byte,
    output logic [DW-1:0]          rx_hold
);

    localparam int unsigned DIV_W = DW * DIV_BYTES;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DW-1:0]    tx;
        logic [DW-1:0]    rx;
    } data_state_t;

    data_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int i = 0; i < int'(DIV_BYTES); i++) begin
                if (addr == REG_AW'(int'(A_DIVLO) + i))
                    s_d.div[i*DW +: DW] = wdata;
            end
            if (addr == A_TXD) s_d.tx = wdata;
        end
        if (rx_valid) s_d.rx = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_val = s_q.div;
    assign tx_byte = s_q.tx;
    assign rx_hold = s_q.rx;

endmodule

// File: rtl/i2cm_host_regs.sv
module i2cm_host_regs
    import i2cm_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned DIV_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    eng_done,
    input  logic                    eng_rxack,
    input  logic                    eng_rxvalid,
    input  logic [DW-1:0]           eng_rxdata,
    output logic                    cmd_start,
    output logic                    cmd_stop,
    output logic                    cmd_read,
    output logic                    cmd_write,
    output logic                    cmd_nack,
    output logic [DW*DIV_BYTES-1:0] clk_div,
    output logic [DW-1:0]           tx_data,
    output logic                    irq_o
);

    localparam int unsigned DIV_W = DW * DIV_BYTES;

    logic    ctrl_wr;
    cmd_t    cmd;
    logic    ctrl_ien;
    logic    st_busy, st_intreq, st_rxack;
    logic [DW-1:0]    rx_byte;
    logic [DIV_W-1:0] div_val;
    logic [DW-1:0]    tx_byte;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

    i2cm_ctrl_reg #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wdata    (bus_wdata),
        .cmd      (cmd),
        .nack_lvl (cmd_nack),
        .ien_lvl  (ctrl_ien)
    );

    i2cm_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ack_req   (bus_wdata[CB_IACK]),
        .eng_done  (eng_done),
        .eng_rxack (eng_rxack),
        .busy      (st_busy),
        .intreq    (st_intreq),
        .rxack     (st_rxack)
    );

    i2cm_data_regs #(.DW(DW), .DIV_BYTES(DIV_BYTES)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rx_valid (eng_rxvalid),
        .rx_byte  (eng_rxdata),
        .div_val  (div_val),
        .tx_byte  (tx_byte),
        .rx_hold  (rx_byte)
    );

    logic unused_iack;
    assign unused_iack = cmd.iack;

    assign cmd_start = cmd.start;
    assign cmd_stop  = cmd.stop;
    assign cmd_read  = cmd.rd;
    assign cmd_write = cmd.wr;
    assign clk_div   = div_val;
    assign tx_data   = tx_byte;
    assign irq_o     = ctrl_ien & st_intreq;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL: begin
                    bus_rdata[CB_NACK] = cmd_nack;
                    bus_rdata[CB_IEN]  = ctrl_ien;
                end
                A_STAT: begin
                    bus_rdata[SB_BUSY]   = st_busy;
                    bus_rdata[SB_RXACK]  = st_rxack;
                    bus_rdata[SB_INTREQ] = st_intreq;
                end
                A_DIVLO: bus_rdata = div_val[DW-1:0];
                A_DIVHI: bus_rdata = div_val[DIV_W-1 -: DW];
                A_TXD:   bus_rdata = tx_byte;
                A_RXD:   bus_rdata = rx_byte;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2cm_host_regs_chk.sv
module i2cm_host_regs_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          eng_done,
    input logic          eng_rxack,
    input logic          eng_rxvalid,
    input logic          cmd_start,
    input logic          cmd_write,
    input logic          st_busy,
    input logic          st_intreq,
    input logic          st_rxack,
    input logic [DW-1:0] rx_byte
);

    assert_busy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> st_busy);

    assert_busy_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !(bus_wr && bus_addr == 3'd0)) |=> !st_busy);

    assert_intreq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> st_intreq);

    assert_intreq_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[2] && !eng_done) |=> !st_intreq);

    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start || cmd_write) |=> !(cmd_start || cmd_write) || $past(bus_wr && bus_addr == 3'd0));

    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_rxvalid |=> $stable(rx_byte));

    assert_rxack_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (st_rxack == $past(eng_rxack)));

endmodule

bind i2cm_host_regs i2cm_host_regs_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .eng_done    (eng_done),
    .eng_rxack   (eng_rxack),
    .eng_rxvalid (eng_rxvalid),
    .cmd_start   (cmd_start),
    .cmd_write   (cmd_write),
    .st_busy     (st_busy),
    .st_intreq   (st_intreq),
    .st_rxack    (st_rxack),
    .rx_byte     (rx_byte)
);

// File: tb/tb_i2cm_host_regs.sv
`timescale 1ns/1ps
module tb_i2cm_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        eng_done = 1'b0;
    logic        eng_rxack = 1'b0;
    logic        eng_rxvalid = 1'b0;
    logic [7:0]  eng_rxdata = '0;
    logic        cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack;
    logic [15:0] clk_div;
    logic [7:0]  tx_data;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    i2cm_host_regs dut (.*);

    // {addr, write data, expected readback}
    localparam logic [23:0] VEC [6] = '{
        {8'd2, 8'h5A, 8'h5A},
        {8'd3, 8'hC3, 8'hC3},
        {8'd4, 8'h96, 8'h96},
        {8'd5, 8'hFF, 8'h00},
        {8'd1, 8'hFF, 8'h00},
        {8'd0, 8'h83, 8'h82}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic done_pulse(input logic ack);
        @(negedge clk);
        eng_done = 1'b1; eng_rxack = ack;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset state
        for (int a = 0; a < 6; a++) begin
            host_rd(3'(a), rd);
            chk("R4 reset read", {8'h0, rd}, 16'h0000);
        end
        chk("R4 reset cmds", {11'h0, cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack}, 16'h0);
        chk("R4 reset irq", {15'h0, irq_o}, 16'h0);

        // R1/R2/R3/R10 vector walk
        for (int i = 0; i < 6; i++) begin
            host_wr(VEC[i][18:16], VEC[i][15:8]);
            host_rd(VEC[i][18:16], rd);
            chk("R1 R2 R3 R10 table", {8'h0, rd}, {8'h0, VEC[i][7:0]});
        end

        // R8
        chk("R8 clk_div", clk_div, 16'hC35A);
        chk("R8 tx_data", {8'h0, tx_data}, 16'h0096);

        // R9 pulses
        host_wr(3'd0, 8'h42);
        chk("R9 start pulse", {14'h0, cmd_start, cmd_nack}, 16'h0002);
        @(negedge clk);
        chk("R9 start self-clear", {15'h0, cmd_start}, 16'h0);
        host_wr(3'd0, 8'h92);
        chk("R9 read pulse+nack", {12'h0, cmd_read, cmd_write, cmd_stop, cmd_nack}, 16'h0009);
        @(negedge clk);
        chk("R9 read clear nack held", {14'h0, cmd_read, cmd_nack}, 16'h0001);

        // R5 busy from control write
        host_rd(3'd1, rd);
        chk("R5 busy set", {8'h0, rd}, 16'h0004);
        chk("R7 irq low", {15'h0, irq_o}, 16'h0);

        // R6 R12 done with NACK
        done_pulse(1'b1);
        host_rd(3'd1, rd);
        chk("R6 R12 done status", {8'h0, rd}, 16'h0003);
        chk("R7 irq high", {15'h0, irq_o}, 16'h1);

        // R6 write without ack keeps request
        host_wr(3'd0, 8'h02);
        host_rd(3'd1, rd);
        chk("R6 no-ack write", {8'h0, rd}, 16'h0007);

        // R5 R6 collision: done + acknowledging control write
        @(negedge clk);
        eng_done = 1'b1; eng_rxack = 1'b0;
        bus_addr = 3'd0; bus_wdata = 8'h06; bus_wr = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; bus_wr = 1'b0;
        host_rd(3'd1, rd);
        chk("R5 R6 R12 collision", {8'h0, rd}, 16'h0005);
        chk("R7 irq after collision", {15'h0, irq_o}, 16'h1);

        // R6 acknowledge alone
        host_wr(3'd0, 8'h06);
        host_rd(3'd1, rd);
        chk("R6 ack clears", {8'h0, rd}, 16'h0004);
        chk("R7 irq cleared", {15'h0, irq_o}, 16'h0);

        // R5 done clears busy, R7 enable gating
        done_pulse(1'b0);
        host_rd(3'd1, rd);
        chk("R5 done clears busy", {8'h0, rd}, 16'h0001);
        host_wr(3'd0, 8'h00);
        host_rd(3'd1, rd);
        chk("R6 request held", {8'h0, rd}, 16'h0005);
        chk("R7 disabled irq", {15'h0, irq_o}, 16'h0);
        host_rd(3'd0, rd);
        chk("R2 ctrl cleared", {8'h0, rd}, 16'h0000);

        // R10 receive byte
        @(negedge clk);
        eng_rxdata = 8'hA5; eng_rxvalid = 1'b1;
        @(negedge clk);
        eng_rxvalid = 1'b0;
        host_rd(3'd5, rd);
        chk("R10 rx load", {8'h0, rd}, 16'h00A5);
        host_wr(3'd5, 8'h11);
        eng_rxdata = 8'h3C;
        @(negedge clk);
        host_rd(3'd5, rd);
        chk("R10 rx hold", {8'h0, rd}, 16'h00A5);

        // R11 unmapped
        host_wr(3'd6, 8'hEE);
        host_rd(3'd6, rd);
        chk("R11 addr 6", {8'h0, rd}, 16'h0);
        host_rd(3'd7, rd);
        chk("R11 addr 7", {8'h0, rd}, 16'h0);
        chk("R8 tx unchanged", {8'h0, tx_data}, 16'h0096);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule